// File: doc/BRIEF.md
# I2S fractional clock generator

This block produces the three clocks an I2S port needs: an audio system clock, a bit clock and a word-select (frame) clock. Everything runs in one fast clock domain. Each reference source arrives as a one-cycle tick strobe in that domain, and the external crystal clock arrives as a level that is sampled into it. The system clock comes from one of two places. It can be the sampled crystal clock. It can also be the output of an accumulator-based fractional divider, which turns the chosen reference into an average rate of reference·M/N.

Software sets the block up through two write-only registers. The control register at address 0 holds the reference choice, the output mux code and the staged M/N pair. The divisor register at address 1 holds the integer bit-clock divisor. Any write to address 1 also commits the staged M/N pair. The bit clock is the system clock divided by that divisor, counted on both system clock edges. The frame clock toggles once every 32 falling edges of the bit clock, so one frame lasts 64 bit-clock periods.

Top module: `i2s_clkgen`

## Requirements
- R1: After reset, sys_clk, bclk, lrclk and frac_ce are low and ratio_bad is high, because the committed M and N are both zero.
- R2: The control word carries M in bits [21:13] and N in bits [12:0]. The divider uses an effective denominator Ne = max(N, 2·M). Starting from a commit, the divider produces exactly floor(k·M/Ne) frac_ce pulses after k selected reference ticks. Two frac_ce pulses are never on adjacent cycles.
- R3: When the committed M or N is zero, ratio_bad is high and no frac_ce pulse is produced.
- R4: A write to address 0 only stages M and N. The staged pair takes effect on the next write to address 1, whatever value that write carries. The commit also clears the accumulator.
- R5: Control bit 31 picks the reference. 0 selects ref0_tick and 1 selects ref1_tick. Ticks on the reference that is not selected have no effect.
- R6: Control bits [30:29] form the mux code. Bit 30 selects the source (1 = fractional, 0 = external). Bit 29 enables the divider, but only together with bit 30. Code 11 runs the divider onto sys_clk. Codes 00 and 01 pass the external clock and stop the divider. Code 10 selects the stopped divider, so sys_clk stays low.
- R7: The source feeding sys_clk changes only in a cycle where the sampled external clock and the fractional output are both low. A request to switch while the external clock is high leaves sys_clk following the external clock.
- R8: Let D be the value in bits [7:0] of address 1, with 0 treated as 1. bclk toggles once every D edges (rising or falling) of sys_clk. A write to address 1 restarts the edge count.
- R9: lrclk toggles only on a bclk falling edge, once every 32 of them. A write to address 1 restarts this count.
- R10: With the external source selected, sys_clk has one rising edge for each rising edge of ext_clk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock for the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref0_tick | input | 1 | Reference source 0 tick strobe |
| ref1_tick | input | 1 | Reference source 1 tick strobe |
| ext_clk | input | 1 | External crystal clock level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = divisor/commit register |
| wr_data | input | 32 | Write data |
| sys_clk | output | 1 | Audio system clock |
| frac_ce | output | 1 | One-cycle pulse per fractional divider event |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame (word-select) clock |
| ratio_bad | output | 1 | Committed M or N is zero |

## Verification
Four properties are checked on every cycle. frac_ce never fires on two adjacent cycles. No pulse appears while the committed ratio is invalid or the divider is gated off. The source switch happens only while both sources are low. bclk and lrclk move only one cycle after a system clock edge and a bit-clock falling edge, respectively. The exact pulse counts can only be shown by the bench scenarios. Those cover the floor(k·M/Ne) law over a sweep of M and N that includes the clamped cases, the staging and commit sequence, the reference choice, each mux code, and the bit-clock and frame ratios for a range of divisors.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;
  // control word field positions (decoded by software, so fixed)
  localparam int REF_BIT = 31;
  localparam int SRC_BIT = 30;
  localparam int ENA_BIT = 29;
  localparam int M_LSB   = 13;
  localparam int N_LSB   = 0;

  typedef enum logic [1:0] {
    MUX_EXT      = 2'b00,
    MUX_EXT_ARM  = 2'b01,
    MUX_FRAC_OFF = 2'b10,
    MUX_FRAC     = 2'b11
  } mux_code_e;
endpackage

// File: rtl/i2s_cfg_regs.sv
module i2s_cfg_regs
  import i2s_clkgen_pkg::*;
#(
  parameter int M_W = 9,
  parameter int N_W = 13,
  parameter int D_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_addr,
  input  logic [31:0]    wr_data,
  output logic           ref_sel,
  output logic [1:0]     mux_code,
  output logic [M_W-1:0] m_act,
  output logic [N_W-1:0] n_act,
  output logic [D_W-1:0] bdiv,
  output logic           commit,
  output logic           ratio_bad
);
  logic           ref_q, ref_n;
  logic [1:0]     mux_q, mux_n;
  logic [M_W-1:0] m_stg_q, m_stg_n, m_act_q, m_act_n;
  logic [N_W-1:0] n_stg_q, n_stg_n, n_act_q, n_act_n;
  logic [D_W-1:0] bdiv_q, bdiv_n;
  logic           commit_q, commit_n;
  logic           unused_bits;

  assign unused_bits = ^wr_data;

  always_comb begin
    ref_n    = ref_q;
    mux_n    = mux_q;
    m_stg_n  = m_stg_q;
    n_stg_n  = n_stg_q;
    m_act_n  = m_act_q;
    n_act_n  = n_act_q;
    bdiv_n   = bdiv_q;
    commit_n = 1'b0;
    if (wr_en && !wr_addr) begin
      ref_n   = wr_data[REF_BIT];
      mux_n   = {wr_data[SRC_BIT], wr_data[ENA_BIT]};
      m_stg_n = wr_data[M_LSB +: M_W];
      n_stg_n = wr_data[N_LSB +: N_W];
    end else if (wr_en && wr_addr) begin
      m_act_n  = m_stg_q;
      n_act_n  = n_stg_q;
      bdiv_n   = wr_data[D_W-1:0];
      commit_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= 1'b0;
      mux_q    <= MUX_EXT;
      m_stg_q  <= '0;
      n_stg_q  <= '0;
      m_act_q  <= '0;
      n_act_q  <= '0;
      bdiv_q   <= '0;
      commit_q <= 1'b0;
    end else begin
      ref_q    <= ref_n;
      mux_q    <= mux_n;
      m_stg_q  <= m_stg_n;
      n_stg_q  <= n_stg_n;
      m_act_q  <= m_act_n;
      n_act_q  <= n_act_n;
      bdiv_q   <= bdiv_n;
      commit_q <= commit_n;
    end
  end

  assign ref_sel   = ref_q;
  assign mux_code  = mux_q;
  assign m_act     = m_act_q;
  assign n_act     = n_act_q;
  assign bdiv      = bdiv_q;
  assign commit    = commit_q;
  assign ratio_bad = (m_act_q == '0) || (n_act_q == '0);
endmodule

// File: rtl/i2s_frac_div.sv
module i2s_frac_div #(
  parameter int M_W = 9,
  parameter int N_W = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_tick,
  input  logic           enable,
  input  logic           clear,
  input  logic [M_W-1:0] m,
  input  logic [N_W-1:0] n,
  output logic           frac_clk,
  output logic           frac_ce
);
  localparam int AW = ((N_W > M_W + 1) ? N_W : M_W + 1) + 1;

  logic [AW-1:0] acc_q, acc_n;
  logic          clk_q, clk_n, ce_q, ce_n;
  logic [AW-1:0] m_ext, two_m, n_ext, n_eff, sum;
  logic          hit;

  always_comb begin
    m_ext = AW'(m);
    two_m = m_ext << 1;
    n_ext = AW'(n);
    n_eff = (n_ext < two_m) ? two_m : n_ext;
    sum   = acc_q + m_ext;
    hit   = (sum >= n_eff);
  end

  always_comb begin
    acc_n = acc_q;
    clk_n = clk_q;
    ce_n  = 1'b0;
    if (!enable || clear) begin
      acc_n = '0;
      clk_n = 1'b0;
    end else if (ref_tick) begin
      if (hit) begin
        acc_n = sum - n_eff;
        clk_n = 1'b1;
        ce_n  = 1'b1;
      end else begin
        acc_n = sum;
        clk_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      clk_q <= 1'b0;
      ce_q  <= 1'b0;
    end else begin
      acc_q <= acc_n;
      clk_q <= clk_n;
      ce_q  <= ce_n;
    end
  end

  assign frac_clk = clk_q;
  assign frac_ce  = ce_q;

  // R2
  ce_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frac_ce |=> !frac_ce);
endmodule

// File: rtl/i2s_clk_mux.sv
module i2s_clk_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic frac_clk,
  input  logic sel_req,
  output logic sys_clk
);
  logic ext_q, ext_n;
  logic act_q, act_n;
  logic sys_q, sys_n;

  always_comb begin
    ext_n = ext_clk;
    act_n = act_q;
    if ((act_q != sel_req) && !ext_q && !frac_clk)
      act_n = sel_req;
    sys_n = act_q ? frac_clk : ext_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      act_q <= 1'b0;
      sys_q <= 1'b0;
    end else begin
      ext_q <= ext_n;
      act_q <= act_n;
      sys_q <= sys_n;
    end
  end

  assign sys_clk = sys_q;

  // R7
  quiet_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> ($past(ext_q) == 1'b0 && $past(frac_clk) == 1'b0));
endmodule

// File: rtl/i2s_bclk_div.sv
module i2s_bclk_div #(
  parameter int D_W        = 8,
  parameter int FRAME_HALF = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sys_clk,
  input  logic           restart,
  input  logic [D_W-1:0] div,
  output logic           bclk,
  output logic           lrclk
);
  localparam int FW = (FRAME_HALF > 1) ? $clog2(FRAME_HALF) : 1;

  logic           sys_d_q, sys_d_n;
  logic [D_W-1:0] ecnt_q, ecnt_n;
  logic           bclk_q, bclk_n, bclk_d_q, bclk_d_n;
  logic [FW-1:0]  fcnt_q, fcnt_n;
  logic           lr_q, lr_n;
  logic           sys_edge, bclk_fall, last_edge;
  logic [D_W-1:0] dlim;

  always_comb begin
    dlim      = (div == '0) ? D_W'(1) : div;
    sys_edge  = sys_clk ^ sys_d_q;
    bclk_fall = bclk_d_q & ~bclk_q;
    last_edge = (ecnt_q >= dlim - D_W'(1));
  end

  always_comb begin
    sys_d_n  = sys_clk;
    bclk_d_n = bclk_q;
    ecnt_n   = ecnt_q;
    bclk_n   = bclk_q;
    fcnt_n   = fcnt_q;
    lr_n     = lr_q;
    if (restart) begin
      ecnt_n = '0;
      fcnt_n = '0;
    end else begin
      if (sys_edge) begin
        if (last_edge) begin
          ecnt_n = '0;
          bclk_n = ~bclk_q;
        end else begin
          ecnt_n = ecnt_q + D_W'(1);
        end
      end
      if (bclk_fall) begin
        if (fcnt_q == FW'(FRAME_HALF - 1)) begin
          fcnt_n = '0;
          lr_n   = ~lr_q;
        end else begin
          fcnt_n = fcnt_q + FW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_d_q  <= 1'b0;
      ecnt_q   <= '0;
      bclk_q   <= 1'b0;
      bclk_d_q <= 1'b0;
      fcnt_q   <= '0;
      lr_q     <= 1'b0;
    end else begin
      sys_d_q  <= sys_d_n;
      ecnt_q   <= ecnt_n;
      bclk_q   <= bclk_n;
      bclk_d_q <= bclk_d_n;
      fcnt_q   <= fcnt_n;
      lr_q     <= lr_n;
    end
  end

  assign bclk  = bclk_q;
  assign lrclk = lr_q;

  // R8
  bclk_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bclk_q) |-> ($past(sys_clk) != $past(sys_clk, 2)));

  // R9
  lr_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lr_q) |-> ($past(bclk_q) == 1'b0 && $past(bclk_q, 2) == 1'b1));
endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_clkgen_pkg::*;
#(
  parameter int M_W        = 9,
  parameter int N_W        = 13,
  parameter int D_W        = 8,
  parameter int FRAME_HALF = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref0_tick,
  input  logic        ref1_tick,
  input  logic        ext_clk,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  output logic        sys_clk,
  output logic        frac_ce,
  output logic        bclk,
  output logic        lrclk,
  output logic        ratio_bad
);
  logic           ref_sel, commit, div_run, sel_tick, frac_clk;
  logic [1:0]     mux_code;
  logic [M_W-1:0] m_act;
  logic [N_W-1:0] n_act;
  logic [D_W-1:0] bdiv;

  i2s_cfg_regs #(.M_W(M_W), .N_W(N_W), .D_W(D_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ref_sel(ref_sel), .mux_code(mux_code),
    .m_act(m_act), .n_act(n_act), .bdiv(bdiv), .commit(commit),
    .ratio_bad(ratio_bad)
  );

  assign sel_tick = ref_sel ? ref1_tick : ref0_tick;
  assign div_run  = (mux_code == MUX_FRAC) && !ratio_bad;

  i2s_frac_div #(.M_W(M_W), .N_W(N_W)) u_frac (
    .clk(clk), .rst_n(rst_n), .ref_tick(sel_tick), .enable(div_run),
    .clear(commit), .m(m_act), .n(n_act), .frac_clk(frac_clk),
    .frac_ce(frac_ce)
  );

  i2s_clk_mux u_mux (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .frac_clk(frac_clk),
    .sel_req(mux_code[1]), .sys_clk(sys_clk)
  );

  i2s_bclk_div #(.D_W(D_W), .FRAME_HALF(FRAME_HALF)) u_bdiv (
    .clk(clk), .rst_n(rst_n), .sys_clk(sys_clk), .restart(commit),
    .div(bdiv), .bclk(bclk), .lrclk(lrclk)
  );

  // R3
  bad_ratio_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_bad && $past(ratio_bad)) |-> !frac_ce);

  // R6
  gated_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frac_ce |-> ($past(mux_code) == MUX_FRAC));
endmodule

// File: tb/i2s_clkgen_tb.sv
module i2s_clkgen_tb;
  logic        clk, rst_n, ref0_tick, ref1_tick, ext_clk, wr_en, wr_addr;
  logic [31:0] wr_data;
  logic        sys_clk, frac_ce, bclk, lrclk, ratio_bad;

  integer n_chk, n_fail;
  integer c_ce, c_sysr, c_btog, c_bfall, c_lr;
  logic   p_sys, p_b, p_lr;
  logic   done;

  i2s_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .ref0_tick(ref0_tick), .ref1_tick(ref1_tick),
    .ext_clk(ext_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sys_clk(sys_clk), .frac_ce(frac_ce), .bclk(bclk), .lrclk(lrclk),
    .ratio_bad(ratio_bad)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (frac_ce) c_ce = c_ce + 1;
      if (sys_clk && !p_sys) c_sysr = c_sysr + 1;
      if (bclk !== p_b) c_btog = c_btog + 1;
      if (!bclk && p_b) c_bfall = c_bfall + 1;
      if (lrclk !== p_lr) c_lr = c_lr + 1;
    end
    p_sys = sys_clk;
    p_b   = bclk;
    p_lr  = lrclk;
  end

  task automatic chk(input string tag, input integer act, input integer exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input logic rs, input logic [1:0] mx,
                                      input integer m, input integer n);
    ctl = {rs, mx, 7'b0, m[8:0], n[12:0]};
  endfunction

  task automatic step(input integer k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    step(1);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic run_ticks(input logic which, input integer t);
    step(2);
    if (which) ref1_tick = 1'b1; else ref0_tick = 1'b1;
    step(t);
    ref0_tick = 1'b0; ref1_tick = 1'b0;
    step(4);
  endtask

  task automatic pulses(input integer p);
    step(2);
    for (int i = 0; i < p; i++) begin
      ext_clk = 1'b1; step(2);
      ext_clk = 1'b0; step(2);
    end
    step(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk = n_chk + 1; n_fail = n_fail + 1;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    integer b, b2, ne, ex;
    done = 1'b0; n_chk = 0; n_fail = 0;
    c_ce = 0; c_sysr = 0; c_btog = 0; c_bfall = 0; c_lr = 0;
    rst_n = 1'b0; ref0_tick = 0; ref1_tick = 0; ext_clk = 0;
    wr_en = 0; wr_addr = 0; wr_data = '0;
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    chk("R1 sys_clk", sys_clk, 0);
    chk("R1 bclk", bclk, 0);
    chk("R1 lrclk", lrclk, 0);
    chk("R1 frac_ce", frac_ce, 0);
    chk("R1 ratio_bad", ratio_bad, 1);

    // R2 / R3 sweep of M and N, 60 ticks on ref0, mux code 11
    for (int m = 1; m <= 6; m++) begin
      for (int n = 0; n <= 20; n++) begin
        wr(1'b0, ctl(1'b0, 2'b11, m, n));
        wr(1'b1, 32'd1);
        b = c_ce;
        run_ticks(1'b0, 60);
        ne = (n < 2 * m) ? 2 * m : n;
        ex = (n == 0) ? 0 : (60 * m) / ne;
        chk((n == 0) ? "R3 ce count N=0" : "R2 ce count", c_ce - b, ex);
        if (n == 0) chk("R3 ratio_bad", ratio_bad, 1);
      end
    end
    // R3 M = 0
    wr(1'b0, ctl(1'b0, 2'b11, 0, 7));
    wr(1'b1, 32'd1);
    b = c_ce;
    run_ticks(1'b0, 40);
    chk("R3 ce count M=0", c_ce - b, 0);
    chk("R3 ratio_bad M=0", ratio_bad, 1);

    // R4 staging and commit
    wr(1'b0, ctl(1'b0, 2'b11, 1, 4));
    wr(1'b1, 32'd1);
    chk("R4 ratio_bad valid", ratio_bad, 0);
    wr(1'b0, ctl(1'b0, 2'b11, 1, 2));
    b = c_ce;
    run_ticks(1'b0, 40);
    chk("R4 staged not applied", c_ce - b, 10);
    wr(1'b1, 32'd1);
    b = c_ce;
    run_ticks(1'b0, 40);
    chk("R4 applied after commit", c_ce - b, 20);

    // R5 reference choice
    wr(1'b0, ctl(1'b1, 2'b11, 1, 2));
    wr(1'b1, 32'd1);
    b = c_ce;
    run_ticks(1'b0, 40);
    chk("R5 unselected ref0 ignored", c_ce - b, 0);
    b = c_ce;
    run_ticks(1'b1, 40);
    chk("R5 ref1 selected", c_ce - b, 20);

    // R6 mux codes
    wr(1'b0, ctl(1'b0, 2'b01, 1, 2));
    wr(1'b1, 32'd1);
    b = c_ce; b2 = c_sysr;
    run_ticks(1'b0, 40);
    chk("R6 code01 ce", c_ce - b, 0);
    chk("R6 code01 sys", c_sysr - b2, 0);
    wr(1'b0, ctl(1'b0, 2'b10, 1, 2));
    wr(1'b1, 32'd1);
    b = c_ce; b2 = c_sysr;
    run_ticks(1'b0, 40);
    chk("R6 code10 ce", c_ce - b, 0);
    chk("R6 code10 sys", c_sysr - b2, 0);
    chk("R6 code10 sys low", sys_clk, 0);
    wr(1'b0, ctl(1'b0, 2'b11, 1, 2));
    wr(1'b1, 32'd1);
    b2 = c_sysr;
    run_ticks(1'b0, 40);
    chk("R6 code11 sys follows divider", c_sysr - b2, 20);

    // R10 / R8 external path and bit clock divisor sweep
    wr(1'b0, ctl(1'b0, 2'b00, 1, 2));
    for (int d = 0; d <= 7; d++) begin
      wr(1'b1, d);
      b = c_btog; b2 = c_sysr;
      pulses(24);
      chk("R10 sys rises", c_sysr - b2, 24);
      chk("R8 bclk toggles", c_btog - b, 48 / ((d == 0) ? 1 : d));
    end

    // R9 frame clock
    wr(1'b1, 32'd1);
    b = c_bfall; b2 = c_lr;
    pulses(100);
    chk("R9 bclk falls", c_bfall - b, 100);
    chk("R9 lrclk toggles", c_lr - b2, (c_bfall - b) / 32);

    // R7 switch waits for both sources low
    ext_clk = 1'b1;
    step(5);
    chk("R7 sys high on ext", sys_clk, 1);
    wr(1'b0, ctl(1'b0, 2'b11, 1, 2));
    wr(1'b1, 32'd1);
    step(5);
    chk("R7 held on ext while high", sys_clk, 1);
    ext_clk = 1'b0;
    step(5);
    chk("R7 low after release", sys_clk, 0);
    b2 = c_sysr;
    run_ticks(1'b0, 40);
    chk("R7 switched to divider", c_sysr - b2, 20);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule